// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block holds a small table of outbound translation windows for a host-side bus bridge. Software programs each window with an enable, a window kind (configuration, I/O or memory), a size mask, a local base address and a 64-bit remote base. Every lookup presents a 32-bit local address. The block compares it against all windows in parallel and picks the lowest-numbered enabled window that matches. It then returns the remote address and the window kind one cycle later.

Sizes are held as an inverted mask, ~(size-1), with a minimum window of 4 KiB. The upper 32 mask bits sit in a separate extension register. Memory and I/O windows replace the masked high bits of the address with the remote base. Configuration windows work differently. They place a bus/device/function target, taken from the top half of the remote low word, above a 12-bit register offset, and they also report that target on dedicated outputs.

Top module: `otw_xlate_top`

## Requirements
- R1: After reset every window is disabled, every register reads 0 and every lookup misses.
- R2: Window w uses four registers at byte offset 16*w: control (+0), local base (+4), remote low (+8) and remote high (+12). Its upper mask word is at 16*NUM_WIN + 4*w. A write at a clock edge with reg_wr high updates the register at reg_addr. reg_rdata returns that register combinationally, and any unmapped address reads 0.
- R3: Bits 1:0 of a local base are stored as zero and read back as zero.
- R4: In the control word, bit 0 is the enable and bits 2:1 are the kind (0 configuration, 1 I/O, 2 memory, 3 reserved). Bits 31:12 are mask bits 31:12. Mask bits 11:0 are always zero, and control bits 11:3 read as zero.
- R5: Window w matches address a when it is enabled, its kind is not 3, and (a & mask_lo) == (base & mask_lo). Here mask_lo is {ctrl[31:12], 12'b0}.
- R6: When several windows match, the lowest index wins. rsp_win reports that index.
- R7: On a miss, rsp_miss=1, rsp_hit=0 and rsp_addr is the request address zero-extended. rsp_win, rsp_type, rsp_bus, rsp_dev and rsp_fn are all 0.
- R8: For a matching I/O or memory window, rsp_addr = (remote & mask) | (zext(a) & ~mask). The full 64-bit mask is {mask_hi, mask_lo}. rsp_bus, rsp_dev and rsp_fn are 0.
- R9: For a matching configuration window, rsp_addr = {remote_hi, remote_lo[31:16], 4'b0, a[11:0]}. rsp_bus = remote_lo[31:24], rsp_dev = remote_lo[23:19] and rsp_fn = remote_lo[18:16].
- R10: All rsp_* outputs are registered. They reflect the request of the previous clock edge, and rsp_valid is req_valid delayed by one cycle.
- R11: A register written at one clock edge governs a lookup presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | WIN_IDX_W | Index of the winning window |
| rsp_type | output | 2 | Kind of the winning window |
| rsp_addr | output | 64 | Translated remote address |
| rsp_bus | output | 8 | Configuration target bus |
| rsp_dev | output | 5 | Configuration target device |
| rsp_fn | output | 3 | Configuration target function |

## Verification
The assertions take for granted that reg_addr and req_addr are driven to known values while reset is low. The miss-passthrough and configuration-offset properties look back one cycle at req_addr. The checks of R5 and R8 also assume that software programs each mask as a contiguous run of ones from the top, so that a window is a true power-of-two region. The random stimulus draws sizes as powers of two from 4 KiB to 8 MiB and aligns bases to their size. It clusters bases into a few 16 MiB regions, so windows overlap and priority is exercised. It also writes junk into the reserved control bits.

// File: rtl/otw_pkg.sv
package otw_pkg;
    localparam int DW        = 32;
    localparam int PAGE_BITS = 12;
    localparam int RA_W      = 2 * DW;

    typedef enum logic [1:0] {
        WT_CFG = 2'd0,
        WT_IO  = 2'd1,
        WT_MEM = 2'd2,
        WT_RSV = 2'd3
    } win_type_e;

    typedef struct packed {
        logic          en;
        win_type_e     wtype;
        logic [DW-1:0] mask_lo;
        logic [DW-1:0] mask_hi;
        logic [DW-1:0] lbase;
        logic [DW-1:0] rlo;
        logic [DW-1:0] rhi;
    } win_cfg_t;

    function automatic logic [RA_W-1:0] win_xlate(input win_cfg_t w, input logic [DW-1:0] a);
        logic [RA_W-1:0] mask;
        logic [RA_W-1:0] remote;
        mask   = {w.mask_hi, w.mask_lo};
        remote = {w.rhi, w.rlo};
        if (w.wtype == WT_CFG)
            return {w.rhi, w.rlo[DW-1:16], 4'b0, a[PAGE_BITS-1:0]};
        return (remote & mask) | ({{DW{1'b0}}, a} & ~mask);
    endfunction
endpackage

// File: rtl/otw_regs.sv
module otw_regs import otw_pkg::*; #(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [DW-1:0]             reg_wdata,
    output logic [DW-1:0]             reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]    cfg
);
    localparam int EXT_BASE = NUM_WIN * 16;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(w * 16);
        localparam logic [REG_AW-1:0] A_LB   = REG_AW'(w * 16 + 4);
        localparam logic [REG_AW-1:0] A_RLO  = REG_AW'(w * 16 + 8);
        localparam logic [REG_AW-1:0] A_RHI  = REG_AW'(w * 16 + 12);
        localparam logic [REG_AW-1:0] A_EXT  = REG_AW'(EXT_BASE + w * 4);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[w] <= '0;
            end else if (reg_wr) begin
                if (reg_addr == A_CTRL) begin
                    cfg[w].en      <= reg_wdata[0];
                    cfg[w].wtype   <= win_type_e'(reg_wdata[2:1]);
                    cfg[w].mask_lo <= {reg_wdata[DW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
                end
                if (reg_addr == A_LB)  cfg[w].lbase   <= {reg_wdata[DW-1:2], 2'b00};
                if (reg_addr == A_RLO) cfg[w].rlo     <= reg_wdata;
                if (reg_addr == A_RHI) cfg[w].rhi     <= reg_wdata;
                if (reg_addr == A_EXT) cfg[w].mask_hi <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (reg_addr == REG_AW'(w * 16))
                reg_rdata = {cfg[w].mask_lo[DW-1:PAGE_BITS], 9'b0, cfg[w].wtype, cfg[w].en};
            if (reg_addr == REG_AW'(w * 16 + 4))        reg_rdata = cfg[w].lbase;
            if (reg_addr == REG_AW'(w * 16 + 8))        reg_rdata = cfg[w].rlo;
            if (reg_addr == REG_AW'(w * 16 + 12))       reg_rdata = cfg[w].rhi;
            if (reg_addr == REG_AW'(EXT_BASE + w * 4))  reg_rdata = cfg[w].mask_hi;
        end
    end
endmodule

// File: rtl/otw_match.sv
module otw_match import otw_pkg::*; #(
    parameter int NUM_WIN = 8
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [DW-1:0]          addr,
    output logic [NUM_WIN-1:0]     hit_vec
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign hit_vec[w] = cfg[w].en && (cfg[w].wtype != WT_RSV) &&
                            ((addr & cfg[w].mask_lo) == (cfg[w].lbase & cfg[w].mask_lo));
    end
endmodule

// File: rtl/otw_prio.sv
module otw_prio #(
    parameter int NUM_WIN   = 8,
    parameter int WIN_IDX_W = 3
) (
    input  logic [NUM_WIN-1:0]   hit_vec,
    output logic                 found,
    output logic [WIN_IDX_W-1:0] idx
);
    always_comb begin
        found = |hit_vec;
        idx   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--)
            if (hit_vec[i]) idx = WIN_IDX_W'(i);
    end
endmodule

// File: rtl/otw_xlate_top.sv
module otw_xlate_top import otw_pkg::*; #(
    parameter int NUM_WIN   = 8,
    parameter int REG_AW    = 8,
    parameter int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [WIN_IDX_W-1:0] rsp_win,
    output logic [1:0]           rsp_type,
    output logic [63:0]          rsp_addr,
    output logic [7:0]           rsp_bus,
    output logic [4:0]           rsp_dev,
    output logic [2:0]           rsp_fn
);
    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hit_vec;
    logic                   any_hit;
    logic [WIN_IDX_W-1:0]   sel;
    win_cfg_t               sel_cfg;
    logic [RA_W-1:0]        nxt_addr;
    logic                   sel_is_cfg;

    otw_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg)
    );

    otw_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg(cfg), .addr(req_addr), .hit_vec(hit_vec)
    );

    otw_prio #(.NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W)) u_prio (
        .hit_vec(hit_vec), .found(any_hit), .idx(sel)
    );

    always_comb begin
        sel_cfg    = cfg[sel];
        sel_is_cfg = any_hit && (sel_cfg.wtype == WT_CFG);
        nxt_addr   = any_hit ? win_xlate(sel_cfg, req_addr) : {{DW{1'b0}}, req_addr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_win   <= '0;
            rsp_type  <= '0;
            rsp_addr  <= '0;
            rsp_bus   <= '0;
            rsp_dev   <= '0;
            rsp_fn    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= any_hit;
            rsp_miss  <= !any_hit;
            rsp_win   <= any_hit ? sel : '0;
            rsp_type  <= any_hit ? sel_cfg.wtype : WT_CFG;
            rsp_addr  <= nxt_addr;
            rsp_bus   <= sel_is_cfg ? sel_cfg.rlo[31:24] : '0;
            rsp_dev   <= sel_is_cfg ? sel_cfg.rlo[23:19] : '0;
            rsp_fn    <= sel_is_cfg ? sel_cfg.rlo[18:16] : '0;
        end
    end
endmodule

// File: rtl/otw_xlate_chk.sv
module otw_xlate_chk #(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              req_valid,
    input logic [31:0]       req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [1:0]        rsp_type,
    input logic [63:0]       rsp_addr
);
    localparam logic [REG_AW-1:0] WIN_END = REG_AW'(NUM_WIN * 16);

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid));

    // R7
    hit_xor_miss_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R7
    miss_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (rsp_addr == {32'b0, $past(req_addr)}));

    // R9
    cfg_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && rsp_type == 2'd0) |->
            (rsp_addr[11:0] == $past(req_addr[11:0]) && rsp_addr[15:12] == 4'b0));

    // R3
    lbase_align_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < WIN_END && reg_addr[3:0] == 4'h4) |-> (reg_rdata[1:0] == 2'b00));

    // R4
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < WIN_END && reg_addr[3:0] == 4'h0) |-> (reg_rdata[11:3] == 9'b0));
endmodule

bind otw_xlate_top otw_xlate_chk #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) chk_i (.*);

// File: tb/otw_xlate_top_tb_top.sv
module otw_xlate_top_tb_top;
    localparam int NW  = 8;
    localparam int RAW = 8;
    localparam int IW  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic rsp_valid, rsp_hit, rsp_miss;
    logic [IW-1:0] rsp_win;
    logic [1:0] rsp_type;
    logic [63:0] rsp_addr;
    logic [7:0] rsp_bus;
    logic [4:0] rsp_dev;
    logic [2:0] rsp_fn;

    always #5 clk = ~clk;

    otw_xlate_top #(.NUM_WIN(NW), .REG_AW(RAW)) dut_i (.*);

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model of programmed state
    logic        m_en  [NW];
    logic [1:0]  m_ty  [NW];
    logic [31:0] m_mlo [NW];
    logic [31:0] m_mhi [NW];
    logic [31:0] m_lb  [NW];
    logic [31:0] m_rlo [NW];
    logic [31:0] m_rhi [NW];

    task automatic model_reset();
        for (int w = 0; w < NW; w++) begin
            m_en[w] = 0; m_ty[w] = 0; m_mlo[w] = 0; m_mhi[w] = 0;
            m_lb[w] = 0; m_rlo[w] = 0; m_rhi[w] = 0;
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        for (int w = 0; w < NW; w++) begin
            if (a == 8'(w*16))    begin m_en[w] = d[0]; m_ty[w] = d[2:1]; m_mlo[w] = {d[31:12], 12'b0}; end
            if (a == 8'(w*16+4))  m_lb[w]  = {d[31:2], 2'b00};
            if (a == 8'(w*16+8))  m_rlo[w] = d;
            if (a == 8'(w*16+12)) m_rhi[w] = d;
            if (a == 8'(NW*16+w*4)) m_mhi[w] = d;
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] r = 0;
        for (int w = 0; w < NW; w++) begin
            if (a == 8'(w*16))      r = {m_mlo[w][31:12], 9'b0, m_ty[w], m_en[w]};
            if (a == 8'(w*16+4))    r = m_lb[w];
            if (a == 8'(w*16+8))    r = m_rlo[w];
            if (a == 8'(w*16+12))   r = m_rhi[w];
            if (a == 8'(NW*16+w*4)) r = m_mhi[w];
        end
        return r;
    endfunction

    // {hit, miss, win, type, addr, bus, dev, fn}
    function automatic logic [86:0] exp_lookup(input logic [31:0] a);
        for (int w = 0; w < NW; w++) begin
            if (m_en[w] && m_ty[w] != 2'd3 && ((a & m_mlo[w]) == (m_lb[w] & m_mlo[w]))) begin
                logic [63:0] mk, ad;
                mk = {m_mhi[w], m_mlo[w]};
                if (m_ty[w] == 2'd0)
                    return {1'b1, 1'b0, 3'(w), 2'd0,
                            m_rhi[w], m_rlo[w][31:16], 4'b0, a[11:0],
                            m_rlo[w][31:24], m_rlo[w][23:19], m_rlo[w][18:16]};
                ad = ({m_rhi[w], m_rlo[w]} & mk) | ({32'b0, a} & ~mk);
                return {1'b1, 1'b0, 3'(w), m_ty[w], ad, 8'b0, 5'b0, 3'b0};
            end
        end
        return {1'b0, 1'b1, 3'b0, 2'b0, 32'b0, a, 16'b0};
    endfunction

    task automatic check(input string req, input logic [86:0] act, input logic [86:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        model_write(a, d);
    endtask

    task automatic rd_check(input string req, input logic [7:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, 87'(reg_rdata), 87'(exp_read(a)));
    endtask

    task automatic lookup(input string req, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check(req, {rsp_hit, rsp_miss, rsp_win, rsp_type, rsp_addr, rsp_bus, rsp_dev, rsp_fn},
              exp_lookup(a));
        checks++;
        if (rsp_valid !== 1'b1) begin
            fails++;
            $display("FAIL R10 rsp_valid act=%b exp=1", rsp_valid);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        for (int w = 0; w < NW; w++) rd_check("R1 ctrl after reset", 8'(w*16));
        lookup("R1 lookup after reset misses", 32'h1234_5678);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin fails++; $display("FAIL R10 idle valid act=%b exp=0", rsp_valid); end

        // R2/R3/R4: register map and field masking
        wr(8'h14, 32'hDEAD_BEEF);
        rd_check("R3 lbase low bits dropped", 8'h14);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_check("R4 ctrl reserved bits read zero", 8'h10);
        wr(8'h18, 32'h0102_0304); rd_check("R2 remote low", 8'h18);
        wr(8'h1C, 32'hA5A5_5A5A); rd_check("R2 remote high", 8'h1C);
        wr(8'h84, 32'hFFFF_FF00); rd_check("R2 mask ext", 8'h84);
        rd_check("R2 unmapped A0", 8'hA0);
        rd_check("R2 unmapped unaligned", 8'h82);
        wr(8'h10, 32'h0);

        // R5/R8: memory window
        wr(8'h04, 32'h4000_0000);
        wr(8'h08, 32'h8765_0000);
        wr(8'h0C, 32'h0000_0012);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFF0_0000 | 32'h5);
        lookup("R8 mem translate", 32'h400A_BCDE);
        lookup("R5 mem edge last byte", 32'h400F_FFFF);
        lookup("R5 mem just above", 32'h4010_0000);

        // R6: overlapping window 5 (I/O) covering the same region
        wr(8'h54, 32'h4000_0000);
        wr(8'h58, 32'hCAFE_0000);
        wr(8'h5C, 32'h0);
        wr(8'h94, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFF00_0000 | 32'h3);
        lookup("R6 lower index wins", 32'h4001_0000);
        wr(8'h00, 32'hFFF0_0004);
        lookup("R6 disabled lower yields to 5", 32'h4001_0000);

        // R4/R5: reserved kind never hits
        wr(8'h50, 32'hFF00_0000 | 32'h7);
        lookup("R5 reserved kind no hit", 32'h4001_0000);

        // R9: configuration window
        wr(8'h24, 32'h6000_0000);
        wr(8'h28, {8'h3C, 5'd17, 3'd5, 16'h0});
        wr(8'h2C, 32'h0000_0001);
        wr(8'h88, 32'hFFFF_FFFF);
        wr(8'h20, 32'hF000_0000 | 32'h1);
        lookup("R9 cfg target and offset", 32'h6ABC_DFED);

        // R11: write then lookup the next cycle
        @(negedge clk);
        reg_wr = 1; reg_addr = 8'h20; reg_wdata = 32'hF000_0000;
        @(negedge clk);
        reg_wr = 0; model_write(8'h20, 32'hF000_0000);
        req_valid = 1; req_addr = 32'h6000_0100;
        @(negedge clk);
        req_valid = 0;
        check("R11 write visible next cycle",
              {rsp_hit, rsp_miss, rsp_win, rsp_type, rsp_addr, rsp_bus, rsp_dev, rsp_fn},
              exp_lookup(32'h6000_0100));

        // random rounds
        for (int r = 0; r < 40; r++) begin
            for (int w = 0; w < NW; w++) begin
                int k;
                logic [31:0] ml, junk;
                k = 12 + int'($urandom % 12);
                ml = ~((32'd1 << k) - 1);
                junk = $urandom & 32'h0000_0FF8;
                wr(8'(w*16+4), ((($urandom % 4) << 24) | ($urandom & 32'h00FF_FFFF)) & ml | ($urandom & 3));
                wr(8'(w*16+8), $urandom);
                wr(8'(w*16+12), $urandom);
                wr(8'(NW*16+w*4), ($urandom % 2) ? 32'hFFFF_FFFF : 32'hFFFF_FF00);
                wr(8'(w*16), ml | junk | (($urandom % 4) << 1) | 32'((($urandom % 4) != 0) ? 1 : 0));
            end
            rd_check("R2 random readback", 8'(($urandom % 8) * 16 + ($urandom % 4) * 4));
            for (int j = 0; j < 25; j++)
                lookup("R5 R6 R8 R9 random lookup", (($urandom % 4) << 24) | ($urandom & 32'h00FF_FFFF));
        end

        // R1: reset again clears state
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; model_reset();
        lookup("R1 lookup after second reset", 32'h0100_0000);
        rd_check("R1 ctrl after second reset", 8'h00);

        done = 1;
        summary();
        $finish;
    end
endmodule